// File: doc/BRIEF.md
# Lane-Partitioned Adder with Dot-Product Accumulate

This unit performs integer arithmetic on 64-bit operand words that can be viewed as one wide element, two 32-bit elements or four 16-bit elements. A single wide adder is cut into 16-bit segments. The carry between two segments is either passed on or blocked, depending on the selected lane width. Each element therefore receives the same operation with no interaction between elements. Add and subtract results are registered and appear one cycle after the operation is accepted.

A third operation supports dot products. In four-lane mode, each pair of signed 16-bit elements is multiplied. The four products are summed into a 48-bit signed accumulator held inside the unit. The updated accumulator is returned sign-extended to 64 bits. This path has one extra pipeline stage, so its results appear two cycles after acceptance. A clear input zeroes the accumulator. The clear travels down the pipeline with the operations, so it takes effect in issue order. Every result is marked by a one-cycle valid strobe.

Top module: `simd_mac_unit`

## Requirements
- R1: mode_i selects the lane layout. 2'b00 is one 64-bit lane. 2'b01 is two 32-bit lanes at bits 31:0 and 63:32. 2'b10 is four 16-bit lanes, with lane k at bits 16k+15:16k. 2'b11 behaves exactly like 2'b00.
- R2: No carry or borrow crosses a lane boundary of the selected layout. Each lane result wraps modulo 2^n, where n is the lane width.
- R3: op_i selects the operation. 2'b00 is add. 2'b01 is subtract (a_i minus b_i). 2'b10 is multiply-accumulate. 2'b11 behaves exactly like add.
- R4: An add or subtract accepted with valid_i at a rising edge is presented on result_o, with valid_o high, immediately after that same edge. It stays valid for one cycle.
- R5: A multiply-accumulate in four-lane mode does two things. It adds the sum of the four signed 16x16 lane products to the 48-bit accumulator, wrapping modulo 2^48. It also returns the updated accumulator, sign-extended to 64 bits, one cycle later than an add would appear.
- R6: A multiply-accumulate in one- or two-lane mode returns the lane-wise sum of the operands with the two-cycle latency. It leaves the accumulator unchanged.
- R7: acc_clr_i is sampled on every cycle, whether or not valid_i is high. It clears the accumulator in issue order. When it is high together with a four-lane multiply-accumulate, the products are added onto zero.
- R8: An add or subtract issued in the cycle right after a multiply-accumulate lands on the same output cycle. In that case the multiply-accumulate result is delivered and the add or subtract result is discarded.
- R9: valid_o is high only for results of accepted operations. During reset, valid_o and result_o are zero.
- R10: Add and subtract operations are accepted on every cycle, back to back, each giving its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| mode_i | input | 2 | Lane layout select |
| op_i | input | 2 | Operation select |
| acc_clr_i | input | 1 | Clear the accumulator |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Result word |

## Verification
The bench sends operands of all ones plus one in every lane layout. A design that leaked a carry across a cut would show a stray 1 at the next lane's low bit, and one that cut too often would lose the 64-bit ripple. Signed products with negative elements drive the accumulator below zero, so a design that used unsigned products or zero-extension would return a large positive value. A clear issued between two accumulates, and a clear issued together with one, expose a clear that acts out of order or after the add. A multiply-accumulate in a wide mode followed by one in four-lane mode catches a design that lets the wide mode disturb the accumulator. An add placed directly behind a multiply-accumulate catches a design that gives the add priority or emits two strobes.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  typedef enum logic [1:0] {
    MODE_X1  = 2'b00,
    MODE_X2  = 2'b01,
    MODE_X4  = 2'b10,
    MODE_RSV = 2'b11
  } lane_mode_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MAC = 2'b10,
    OP_RSV = 2'b11
  } lane_op_e;
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  localparam int NUM_SEG = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic               sub_i,
  input  logic [NUM_SEG-1:1] cut_i,   // segment g starts a new lane
  output logic [DATA_W-1:0]  sum_o
);
  logic [NUM_SEG-2:0] cout;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic             cin;
    logic [SEG_W-1:0] bx;
    assign bx = b_i[g*SEG_W +: SEG_W] ^ {SEG_W{sub_i}};
    if (g == 0) begin : g_first
      assign cin = sub_i;
    end else begin : g_rest
      assign cin = cut_i[g] ? sub_i : cout[g-1];
    end
    if (g < NUM_SEG-1) begin : g_mid
      logic [SEG_W:0] s;
      assign s = {1'b0, a_i[g*SEG_W +: SEG_W]} + {1'b0, bx} + {{SEG_W{1'b0}}, cin};
      assign sum_o[g*SEG_W +: SEG_W] = s[SEG_W-1:0];
      assign cout[g] = s[SEG_W];
    end else begin : g_top
      assign sum_o[g*SEG_W +: SEG_W] = a_i[g*SEG_W +: SEG_W] + bx + {{(SEG_W-1){1'b0}}, cin};
    end
  end
endmodule

// File: rtl/simd_lane_mul.sv
module simd_lane_mul #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  localparam int NUM_SEG = DATA_W / SEG_W,
  localparam int PROD_W  = 2 * SEG_W
) (
  input  logic [DATA_W-1:0]              a_i,
  input  logic [DATA_W-1:0]              b_i,
  output logic [NUM_SEG-1:0][PROD_W-1:0] prod_o
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_mul
    assign prod_o[g] = $signed(a_i[g*SEG_W +: SEG_W]) * $signed(b_i[g*SEG_W +: SEG_W]);
  end
endmodule

// File: rtl/simd_acc.sv
module simd_acc #(
  parameter int NUM_SEG = 4,
  parameter int PROD_W  = 32,
  parameter int ACC_W   = 48
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           en_i,
  input  logic [NUM_SEG-1:0][PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]               acc_nxt_o
);
  logic [ACC_W-1:0] acc_q, psum;

  always_comb begin
    psum = '0;
    for (int i = 0; i < NUM_SEG; i++)
      psum = psum + {{(ACC_W-PROD_W){prod_i[i][PROD_W-1]}}, prod_i[i]};
  end

  // clear first, then accumulate: clear and products in one slot start from zero
  assign acc_nxt_o = (clr_i ? '0 : acc_q) + (en_i ? psum : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            acc_q <= '0;
    else if (clr_i || en_i) acc_q <= acc_nxt_o;
  end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import simd_mac_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int ACC_W  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        op_i,
  input  logic              acc_clr_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int NUM_SEG = DATA_W / SEG_W;
  localparam int PROD_W  = 2 * SEG_W;
  localparam int SEGS_X2 = NUM_SEG / 2;

  lane_mode_e mode_eff;
  lane_op_e   op;
  logic       is_mac;
  logic [NUM_SEG-1:1] cut;
  logic [DATA_W-1:0]  sum;
  logic [NUM_SEG-1:0][PROD_W-1:0] prod;

  assign op       = lane_op_e'(op_i);
  assign is_mac   = (op == OP_MAC);
  assign mode_eff = (lane_mode_e'(mode_i) == MODE_RSV) ? MODE_X1 : lane_mode_e'(mode_i);

  for (genvar g = 1; g < NUM_SEG; g++) begin : g_cut
    if (g % SEGS_X2 == 0) begin : g_half
      assign cut[g] = (mode_eff == MODE_X4) || (mode_eff == MODE_X2);
    end else begin : g_quarter
      assign cut[g] = (mode_eff == MODE_X4);
    end
  end

  simd_lane_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_add (
    .a_i(a_i), .b_i(b_i), .sub_i(op == OP_SUB), .cut_i(cut), .sum_o(sum)
  );

  simd_lane_mul #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_mul (
    .a_i(a_i), .b_i(b_i), .prod_o(prod)
  );

  // stage 1 of the accumulate path
  logic                           s1_mac, s1_quad, s1_clr;
  logic [DATA_W-1:0]              s1_sum;
  logic [NUM_SEG-1:0][PROD_W-1:0] s1_prod;
  logic [ACC_W-1:0]               acc_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_mac  <= 1'b0;
      s1_quad <= 1'b0;
      s1_clr  <= 1'b0;
      s1_sum  <= '0;
      s1_prod <= '0;
    end else begin
      s1_mac <= valid_i && is_mac;
      s1_clr <= acc_clr_i;
      if (valid_i && is_mac) begin
        s1_quad <= (mode_eff == MODE_X4);
        s1_sum  <= sum;
        s1_prod <= prod;
      end
    end
  end

  simd_acc #(.NUM_SEG(NUM_SEG), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(s1_clr), .en_i(s1_mac && s1_quad),
    .prod_i(s1_prod), .acc_nxt_o(acc_nxt)
  );

  // output slot: an accumulate in flight wins over a fresh add/sub
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else if (s1_mac) begin
      valid_o  <= 1'b1;
      result_o <= s1_quad ? {{(DATA_W-ACC_W){acc_nxt[ACC_W-1]}}, acc_nxt} : s1_sum;
    end else if (valid_i && !is_mac) begin
      valid_o  <= 1'b1;
      result_o <= sum;
    end else begin
      valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_mac_unit_chk.sv
module simd_mac_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [1:0]  mode_i,
  input logic [1:0]  op_i,
  input logic [63:0] a_i,
  input logic [63:0] b_i,
  input logic        valid_o,
  input logic [63:0] result_o
);
  logic vin_d1, mac_d1, mac_d2, macq_d1, macq_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vin_d1 <= 1'b0; mac_d1 <= 1'b0; mac_d2 <= 1'b0; macq_d1 <= 1'b0; macq_d2 <= 1'b0;
    end else begin
      vin_d1  <= valid_i;
      mac_d1  <= valid_i && op_i == 2'b10;
      mac_d2  <= mac_d1;
      macq_d1 <= valid_i && op_i == 2'b10 && mode_i == 2'b10;
      macq_d2 <= macq_d1;
    end
  end

  p_addsub_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != 2'b10 |=> valid_o);

  p_mac_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b10 |=> ##1 valid_o);

  p_sign_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && macq_d2 |-> (result_o[63:47] == '0 || result_o[63:47] == '1));

  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> vin_d1 || mac_d2);

  p_lane_iso_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b00 && mode_i == 2'b10 && !mac_d1
    |=> result_o[31:16] == $past(a_i[31:16] + b_i[31:16]));
endmodule

bind simd_mac_unit simd_mac_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/simd_mac_unit_test.sv
module simd_mac_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [1:0]  op_i = 2'b00;
  logic        acc_clr_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  int          due_q[$];
  logic [47:0] acc_m = '0;
  bit          mac_prev = 0;

  simd_mac_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i), .op_i(op_i),
    .acc_clr_i(acc_clr_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [63:0] lane_res(logic [63:0] a, logic [63:0] b, logic [1:0] m, bit sub);
    logic [63:0] r;
    if (m == 2'b10) begin
      for (int i = 0; i < 4; i++)
        r[i*16 +: 16] = sub ? a[i*16 +: 16] - b[i*16 +: 16] : a[i*16 +: 16] + b[i*16 +: 16];
    end else if (m == 2'b01) begin
      for (int i = 0; i < 2; i++)
        r[i*32 +: 32] = sub ? a[i*32 +: 32] - b[i*32 +: 32] : a[i*32 +: 32] + b[i*32 +: 32];
    end else begin
      r = sub ? a - b : a + b;
    end
    return r;
  endfunction

  function automatic logic [47:0] dot4(logic [63:0] a, logic [63:0] b);
    longint s = 0;
    for (int i = 0; i < 4; i++)
      s += longint'($signed(a[i*16 +: 16])) * longint'($signed(b[i*16 +: 16]));
    return s[47:0];
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [1:0] mode, logic [63:0] a, logic [63:0] b,
                       bit clr, string tag);
    logic [63:0] e;
    int lat;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; mode_i = mode; a_i = a; b_i = b; acc_clr_i = clr;
    if (clr) acc_m = '0;
    if (op == 2'b10) begin
      lat = 2;
      if (mode == 2'b10) begin
        acc_m = acc_m + dot4(a, b);
        e = {{16{acc_m[47]}}, acc_m};
      end else e = lane_res(a, b, mode, 0);
    end else begin
      lat = 1;
      e = lane_res(a, b, mode, op == 2'b01);
    end
    if (!(mac_prev && op != 2'b10)) begin   // R8: add/sub right behind a MAC is dropped
      exp_q.push_back(e); tag_q.push_back(tag); due_q.push_back(cyc + lat);
    end
    mac_prev = (op == 2'b10);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; acc_clr_i = 1'b0;
      mac_prev = 0;
    end
  endtask

  task automatic clear_only();
    @(negedge clk_i);
    valid_i = 1'b0; acc_clr_i = 1'b1;
    acc_m = '0;
    mac_prev = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 R8: unexpected valid, got %h expected none", result_o);
      end else begin
        logic [63:0] e;
        string t;
        int d;
        e = exp_q.pop_front(); t = tag_q.pop_front(); d = due_q.pop_front();
        check(t, result_o, e);
        n_cmp++;
        if (d != cyc) begin
          n_bad++;
          $display("FAIL %s latency: got cycle %0d expected %0d", t, cyc, d);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [63:0] RIP = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES_LANE = 64'h0001_0001_0001_0001;

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset valid", {63'd0, valid_o}, 64'd0);
    check("R9 reset result", result_o, 64'd0);
    rst_ni = 1'b1;

    // R1 R2 R4 R10: carry ripple vs. cut, back to back
    issue(2'b00, 2'b00, RIP, 64'd1, 0, "R1 R4");
    issue(2'b00, 2'b01, RIP, 64'd1, 0, "R2 R10");
    issue(2'b00, 2'b10, RIP, 64'd1, 0, "R2 R10");
    issue(2'b00, 2'b10, ONES_LANE * 16'hFFFF, ONES_LANE, 0, "R2 wrap");
    issue(2'b00, 2'b11, RIP, 64'd1, 0, "R1 mode3");
    issue(2'b00, 2'b01, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 0, "R2 dual");
    // R3: subtract borrows
    issue(2'b01, 2'b00, 64'd0, 64'd1, 0, "R3 sub x1");
    issue(2'b01, 2'b01, 64'd0, 64'd1, 0, "R3 R2 sub x2");
    issue(2'b01, 2'b10, 64'd0, ONES_LANE, 0, "R3 R2 sub x4");
    issue(2'b11, 2'b10, RIP, 64'd1, 0, "R3 op3");
    idle(3);

    // R5: dot products, signed
    clear_only();
    issue(2'b10, 2'b10, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, 0, "R5 dot");
    idle(1);
    issue(2'b10, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 0, "R5 negative");
    // R6: wide MAC leaves accumulator, then four-lane continues
    issue(2'b10, 2'b01, RIP, 64'd1, 0, "R6 x2");
    issue(2'b10, 2'b00, RIP, 64'd1, 0, "R6 x1");
    issue(2'b10, 2'b10, ONES_LANE, ONES_LANE, 0, "R6 R5 continue");
    // R7: clear with MAC, clear between MACs
    issue(2'b10, 2'b10, 64'h0002_0002_0002_0002, 64'h0003_0003_0003_0003, 1, "R7 clr with");
    clear_only();
    issue(2'b10, 2'b10, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_FFFF, 0, "R7 clr between");
    idle(2);
    // R8: collision, then spaced add
    issue(2'b10, 2'b10, ONES_LANE, ONES_LANE, 0, "R8 mac");
    issue(2'b00, 2'b10, RIP, 64'd1, 0, "R8 dropped");
    idle(1);
    issue(2'b10, 2'b10, ONES_LANE, ONES_LANE, 0, "R5 R10 mac");
    idle(1);
    issue(2'b00, 2'b00, RIP, RIP, 0, "R10 after gap");
    idle(5);

    check("R9 drained", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule